// File: doc/BRIEF.md
# DC-Only Residual Reconstruction Adder

When the residual of a transform block holds nothing but its DC coefficient, the full inverse transform is not needed. This block takes the place of that transform. It scales the DC term in two integer rounding stages chosen by the block shape. It then adds the scaled value, with saturation, to every predicted pixel of the block.

Predicted pixels arrive one row per beat on a ready/valid input. The DC coefficient and the shape are taken from the first row of each block. Every accepted row comes back reconstructed on a registered ready/valid output one cycle later. The last row of each block is flagged. Blocks 8 tall take eight beats and blocks 4 tall take four.

Top module: `dc_only_adder`

## Requirements
- R1: After reset, out_valid is 0 and out_row is all zeros.
- R2: Shape code 0 (8 wide, 8 tall) scales DC d as t=(3d+1)>>1 followed by (3t+16)>>5.
- R3: Shape code 1 (8 wide, 4 tall) scales as t=(3d+1)>>1 followed by (17t+64)>>7.
- R4: Shape code 2 (4 wide, 8 tall) scales as t=(17d+4)>>3 followed by (12t+64)>>7.
- R5: Shape code 3 (4 wide, 4 tall) scales as t=(17d+4)>>3 followed by (17t+64)>>7.
- R6: Every right shift is arithmetic, so negative DC values round toward minus infinity.
- R7: Each output pixel equals the input pixel plus the scaled DC, clamped to 0..255. Pixel i occupies bits [8i+7:8i] of the row.
- R8: For the 4-wide shapes (codes 2 and 3), pixels 0..3 are reconstructed and pixels 4..7 of the output row are zero.
- R9: DC and shape are sampled on the first row of a block. The values on in_dc and in_shape during the block's later rows have no effect.
- R10: A block lasts 4 rows when bit 0 of the shape code is 1, and 8 rows otherwise. out_last is 1 exactly on the block's final row, and the row after it starts a new block.
- R11: A row accepted at a clock edge (in_valid and in_ready both 1) appears on out_row with out_valid set after that edge. in_ready is 1 whenever out_valid is 0 or out_ready is 1.
- R12: While out_valid is 1 and out_ready is 0, out_row and out_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input row is present |
| in_ready | output | 1 | Block can take a row this cycle |
| in_dc | input | DC_W | Signed DC coefficient, sampled on the first row of a block |
| in_shape | input | 2 | Shape code: 0 8x8, 1 8 wide 4 tall, 2 4 wide 8 tall, 3 4x4 |
| in_row | input | LANES*PIX_W | Predicted pixels, pixel i at bits [8i+7:8i] |
| out_valid | output | 1 | Reconstructed row is present |
| out_ready | input | 1 | Consumer takes the output row |
| out_row | output | LANES*PIX_W | Reconstructed pixels |
| out_last | output | 1 | Row is the final row of its block |

## Verification
The assertions assume that in_dc lies within its signed DC_W-bit range. They also assume that the producer sends complete blocks: a block whose rows are cut short would shift every later block boundary. The stimulus keeps to this by always sending every row of each block. It sweeps DC over the signed range near zero and out to both extremes, and it includes rows of all 0 and all 255 so that both clamps are reached. It also changes in_dc and in_shape in the middle of some blocks, and holds out_ready low during one block to create a stall.

// File: rtl/dcadd_pkg.sv
package dcadd_pkg;
  typedef enum logic [1:0] {
    SHP_W8_H8 = 2'd0,
    SHP_W8_H4 = 2'd1,
    SHP_W4_H8 = 2'd2,
    SHP_W4_H4 = 2'd3
  } dc_shape_e;

  function automatic logic shape_narrow(input logic [1:0] s);
    return s[1];
  endfunction

  function automatic logic shape_short(input logic [1:0] s);
    return s[0];
  endfunction
endpackage

// File: rtl/dcadd_scaler.sv
module dcadd_scaler #(
  parameter int DC_W  = 12,
  parameter int MID_W = DC_W + 6
) (
  input  logic [DC_W-1:0]         dc,
  input  logic [1:0]              shape,
  output logic signed [MID_W-1:0] scaled
);
  import dcadd_pkg::*;

  logic signed [MID_W-1:0] x, p1, s1, p2, s2;

  always_comb begin
    x = {{(MID_W-DC_W){dc[DC_W-1]}}, dc};
    // first stage depends on the block width
    if (shape_narrow(shape)) begin
      p1 = (x <<< 4) + x + MID_W'(4);
      s1 = p1 >>> 3;
    end else begin
      p1 = (x <<< 1) + x + MID_W'(1);
      s1 = p1 >>> 1;
    end
    // second stage depends on the block height; 12t+64>>7 equals 3t+16>>5
    if (shape_short(shape)) begin
      p2 = (s1 <<< 4) + s1 + MID_W'(64);
      s2 = p2 >>> 7;
    end else begin
      p2 = (s1 <<< 1) + s1 + MID_W'(16);
      s2 = p2 >>> 5;
    end
    scaled = s2;
  end

  // R6: a non-negative coefficient never yields a negative scaled term
  always_comb begin
    a_r6_sign_kept: assert (dc[DC_W-1] || !scaled[MID_W-1]);
  end
endmodule

// File: rtl/dcadd_lane.sv
module dcadd_lane #(
  parameter int PIX_W = 8,
  parameter int MID_W = 18
) (
  input  logic                    active,
  input  logic [PIX_W-1:0]        pix,
  input  logic signed [MID_W-1:0] dc,
  output logic [PIX_W-1:0]        res
);
  logic signed [MID_W:0] sum;

  always_comb begin
    sum = $signed({{(MID_W+1-PIX_W){1'b0}}, pix}) + $signed({dc[MID_W-1], dc});
    if (!active)
      res = '0;
    else if (sum[MID_W])
      res = '0;
    else if (|sum[MID_W-1:PIX_W])
      res = '1;
    else
      res = sum[PIX_W-1:0];
  end
endmodule

// File: rtl/dcadd_seq.sv
module dcadd_seq #(
  parameter int MID_W    = 18,
  parameter int MAX_ROWS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    accept,
  input  logic [1:0]              in_shape,
  input  logic signed [MID_W-1:0] in_scaled,
  output logic [1:0]              eff_shape,
  output logic signed [MID_W-1:0] eff_dc,
  output logic                    eff_last
);
  import dcadd_pkg::*;
  localparam int CNT_W = $clog2(MAX_ROWS);

  logic [CNT_W-1:0]        row_cnt;
  logic [1:0]              held_shape;
  logic signed [MID_W-1:0] held_dc;
  logic                    first;
  logic [CNT_W-1:0]        final_row;

  always_comb begin
    first     = (row_cnt == '0);
    eff_shape = first ? in_shape : held_shape;
    eff_dc    = first ? in_scaled : held_dc;
    final_row = shape_short(eff_shape) ? CNT_W'(MAX_ROWS/2 - 1) : CNT_W'(MAX_ROWS - 1);
    eff_last  = (row_cnt == final_row);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_cnt    <= '0;
      held_shape <= '0;
      held_dc    <= '0;
    end else if (accept) begin
      if (first) begin
        held_shape <= in_shape;
        held_dc    <= in_scaled;
      end
      row_cnt <= eff_last ? '0 : row_cnt + 1'b1;
    end
  end

  // R9: inside a block the sampled DC term stays fixed
  a_r9_held_stable: assert property (@(posedge clk) disable iff (rst)
    (accept && !first) |=> ($stable(held_dc) && $stable(held_shape)));
endmodule

// File: rtl/dc_only_adder.sv
module dc_only_adder #(
  parameter int DC_W  = 12,
  parameter int PIX_W = 8,
  parameter int LANES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [DC_W-1:0]        in_dc,
  input  logic [1:0]             in_shape,
  input  logic [LANES*PIX_W-1:0] in_row,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*PIX_W-1:0] out_row,
  output logic                   out_last
);
  import dcadd_pkg::*;
  localparam int MID_W  = DC_W + 6;
  localparam int HALF   = LANES / 2;
  localparam int ROW_W  = LANES * PIX_W;

  logic                    accept;
  logic signed [MID_W-1:0] scaled, eff_dc;
  logic [1:0]              eff_shape;
  logic                    eff_last;
  logic [ROW_W-1:0]        next_row;
  logic                    out_narrow;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  dcadd_scaler #(.DC_W(DC_W), .MID_W(MID_W)) u_scale (
    .dc(in_dc), .shape(in_shape), .scaled(scaled)
  );

  dcadd_seq #(.MID_W(MID_W), .MAX_ROWS(8)) u_seq (
    .clk(clk), .rst(rst), .accept(accept),
    .in_shape(in_shape), .in_scaled(scaled),
    .eff_shape(eff_shape), .eff_dc(eff_dc), .eff_last(eff_last)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic act;
    assign act = (i < HALF) || !shape_narrow(eff_shape);
    dcadd_lane #(.PIX_W(PIX_W), .MID_W(MID_W)) u_lane (
      .active(act),
      .pix(in_row[i*PIX_W +: PIX_W]),
      .dc(eff_dc),
      .res(next_row[i*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_row    <= '0;
      out_last   <= 1'b0;
      out_narrow <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_row    <= next_row;
      out_last   <= eff_last;
      out_narrow <= shape_narrow(eff_shape);
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  a_r11_accept_gives_valid: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  a_r12_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_last)));

  a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_narrow) |-> (out_row[ROW_W-1:HALF*PIX_W] == '0));
endmodule

// File: tb/sim_dc_only_adder.sv
module sim_dc_only_adder;
  localparam int DC_W = 12;
  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic in_ready;
  logic [DC_W-1:0] in_dc = '0;
  logic [1:0] in_shape = '0;
  logic [63:0] in_row = '0;
  logic out_valid;
  logic out_ready = 1;
  logic [63:0] out_row;
  logic out_last;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dc_only_adder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dc(in_dc), .in_shape(in_shape), .in_row(in_row),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_row(out_row), .out_last(out_last)
  );

  function automatic int exp_scale(int d, int s);
    int v = d;
    if (s >= 2) v = (17*v + 4) >>> 3; else v = (3*v + 1) >>> 1;
    if (s[0])   v = (17*v + 64) >>> 7; else v = (3*v + 16) >>> 5;
    return v;
  endfunction

  function automatic logic [63:0] exp_row(logic [63:0] pix, int sdc, int s);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      int v = int'(pix[i*8 +: 8]) + sdc;
      if (s >= 2 && i >= 4) v = 0;
      else if (v < 0) v = 0;
      else if (v > 255) v = 255;
      r[i*8 +: 8] = v[7:0];
    end
    return r;
  endfunction

  function automatic bit clamps(logic [63:0] pix, int sdc);
    for (int i = 0; i < 8; i++) begin
      int v = int'(pix[i*8 +: 8]) + sdc;
      if (v < 0 || v > 255) return 1;
    end
    return 0;
  endfunction

  function automatic logic [63:0] make_row(int blk, int r, int pat);
    logic [63:0] p;
    for (int i = 0; i < 8; i++) begin
      int v = (blk*37 + r*91 + i*53 + pat*11) & 255;
      p[i*8 +: 8] = v[7:0];
    end
    if (pat == 1) p = '0;
    if (pat == 2) p = '1;
    return p;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_row(int dc, int s, logic [63:0] pix);
    @(negedge clk);
    in_dc = DC_W'(dc);
    in_shape = s[1:0];
    in_row = pix;
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic run_block(int dc, int s, int blk, int pat, bit perturb);
    int rows = s[0] ? 4 : 8;
    int sdc = exp_scale(dc, s);
    for (int r = 0; r < rows; r++) begin
      logic [63:0] pix = make_row(blk, r, pat);
      logic [63:0] e = exp_row(pix, sdc, s);
      string tag;
      if (perturb && r > 0) begin
        send_row(-dc - 5, 3 - s, pix);
        tag = "R9";
      end else begin
        send_row(dc, s, pix);
        tag = (dc < 0) ? "R6" : (s == 0 ? "R2" : s == 1 ? "R3" : s == 2 ? "R4" : "R5");
      end
      check(out_valid === 1'b1, "R11", 64'(out_valid), 64'd1);
      check(out_row === e, tag, out_row, e);
      if (clamps(pix, sdc)) check(out_row === e, "R7", out_row, e);
      if (s >= 2) check(out_row[63:32] === 32'd0, "R8", 64'(out_row[63:32]), 64'd0);
      check(out_last === (r == rows-1), "R10", 64'(out_last), 64'(r == rows-1));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(out_valid === 1'b0, "R1", 64'(out_valid), 64'd0);
    check(out_row === 64'd0, "R1", out_row, 64'd0);
    begin
      int blk = 0;
      for (int s = 0; s < 4; s++) begin
        for (int d = -700; d <= 700; d += 13) begin
          run_block(d, s, blk, blk % 3, 0);
          blk++;
        end
        run_block(-2048, s, blk, 0, 0); blk++;
        run_block(2047, s, blk, 1, 0); blk++;
        run_block(-2048, s, blk, 2, 0); blk++;
        run_block(0, s, blk, 2, 0); blk++;
        run_block(-1, s, blk, 1, 0); blk++;
        run_block(333, s, blk, 0, 1); blk++;
        run_block(-97, s, blk, 0, 1); blk++;
      end
    end
    // stall: hold the output and offer a new row
    begin
      logic [63:0] p0 = make_row(5, 0, 0);
      logic [63:0] p1 = make_row(5, 1, 0);
      logic [63:0] e0 = exp_row(p0, exp_scale(150, 3), 3);
      logic [63:0] e1 = exp_row(p1, exp_scale(150, 3), 3);
      @(negedge clk);
      out_ready = 0;
      send_row(150, 3, p0);
      check(out_row === e0, "R5", out_row, e0);
      in_row = p1; in_dc = DC_W'(150); in_shape = 2'd3; in_valid = 1;
      repeat (3) begin
        @(negedge clk);
        check(in_ready === 1'b0, "R11", 64'(in_ready), 64'd0);
        check(out_valid === 1'b1 && out_row === e0, "R12", out_row, e0);
        check(out_last === 1'b0, "R12", 64'(out_last), 64'd0);
      end
      out_ready = 1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 0;
      check(out_row === e1, "R12", out_row, e1);
      for (int r = 2; r < 4; r++) begin
        logic [63:0] p = make_row(5, r, 0);
        logic [63:0] e = exp_row(p, exp_scale(150, 3), 3);
        send_row(150, 3, p);
        check(out_row === e, "R5", out_row, e);
        check(out_last === (r == 3), "R10", 64'(out_last), 64'(r == 3));
      end
      @(negedge clk);
      check(out_valid === 1'b0, "R11", 64'(out_valid), 64'd0);
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule